// File: doc/BRIEF.md
# Converter Result and Load-Byte Serial Port

This block is a slave serial port that lets a host read conversion results and write the 8-bit load value that sets the converter's phase lengths. It uses three wires: data in, data out and a data clock driven by the host. An active-low read select gates reads and an active-low load strobe gates writes. All host pins are synchronized into the system clock domain and edge-detected there, so the host data clock must run at no more than a quarter of the system clock rate.

When read select falls, the port takes a snapshot of the current result into an 18-bit frame and drives its first bit right away. The frame holds the overrange flag, the polarity flag and a 16-bit magnitude. Later bits follow on each falling edge of the data clock. Raising read select ends the read and releases the output at any time.

While the load strobe is low, the port shifts in bits on rising data-clock edges. On the strobe's rising edge it hands the byte to the sequencer as a new load value, together with a one-cycle update pulse. The output pad's tri-state buffer sits outside the block and is driven by the data/enable pair.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, `sdo_oe_o` is 0, `sdo_o` is 0, `load_val_o` equals the parameter `LOAD_RST` (default 0x00) and `load_upd_o` is 0.
- R2: Within three system clocks of `rd_ni` falling, `sdo_oe_o` is 1 and `sdo_o` shows the overrange bit, before any data-clock edge.
- R3: The frame order is overrange, then polarity, then magnitude bits 15 down to 0. Each falling edge of `sclk_i` during a read advances `sdo_o` by one bit, and the new bit is valid within three system clocks.
- R4: The result is captured when `rd_ni` falls. Changes on `res_ovr_i`, `res_pol_i` or `res_mag_i` during the read do not alter the frame being shifted out.
- R5: Raising `rd_ni` at any point drives `sdo_oe_o` to 0 (and `sdo_o` to 0) within three system clocks. The next read restarts from the overrange bit of a fresh snapshot.
- R6: Once all 18 bits have been shifted out, further falling edges of `sclk_i` during the same read leave `sdo_o` at 0.
- R7: `sclk_i` edges while `rd_ni` is high do not shift the frame. The next read still starts with the overrange bit.
- R8: While `ld_ni` is low, `sdi_i` is sampled on each rising edge of `sclk_i`, MSB first. On the rising edge of `ld_ni`, `load_val_o` takes the shifted byte and `load_upd_o` pulses high for exactly one system clock.
- R9: The input shift register clears when `ld_ni` falls. If fewer than 8 bits are sent, they end up right-aligned with zeros above. If more than 8 are sent, only the last 8 are kept.
- R10: `load_val_o` changes only on a rising edge of `ld_ni`. Rising edges of `sclk_i` while `ld_ni` is high, such as those during a read, leave it unchanged and produce no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host data clock (asynchronous) |
| sdi_i | input | 1 | Serial data in, sampled on sclk rising edge |
| rd_ni | input | 1 | Active-low read select |
| ld_ni | input | 1 | Active-low load strobe |
| res_ovr_i | input | 1 | Overrange flag of the latest result |
| res_pol_i | input | 1 | Polarity flag of the latest result |
| res_mag_i | input | 16 | Magnitude of the latest result |
| sdo_o | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe_o | output | 1 | Output enable for the external tri-state pad |
| load_val_o | output | 8 | Load value handed to the sequencer |
| load_upd_o | output | 1 | One-cycle pulse when load_val_o is updated |

## Verification
The bench changes the result inputs right after read select falls. A port that samples the result live, instead of taking a snapshot, would send the new bits. It aborts a read midway and toggles the data clock while select is high: a port that kept a bit count across reads, or shifted while deselected, would start the next frame past the overrange bit. It shifts more bits than the frame holds to catch a wrap-around, and writes short and overlong load sequences to expose a register that is not cleared or that keeps the wrong end of the stream. It also clocks reads with the strobe high, so a port that shifts load bits regardless of the strobe would corrupt the load value.

// File: rtl/csp_pkg.sv
package csp_pkg;
  // synchronized host pins, one bit each
  typedef struct packed {
    logic sclk;
    logic sdi;
    logic rd_n;
    logic ld_n;
  } pins_t;

  localparam int PIN_W = $bits(pins_t);
  localparam pins_t PIN_IDLE = '{sclk: 1'b0, sdi: 1'b0, rd_n: 1'b1, ld_n: 1'b1};
endpackage

// File: rtl/csp_sync_edge.sv
module csp_sync_edge #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= RST_VAL;
          else         stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= RST_VAL;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= RST_VAL;
    else         last_q <= stage_q[STAGES-1];
  end

  assign sync_o = stage_q[STAGES-1];
  assign rise_o = stage_q[STAGES-1] & ~last_q;
  assign fall_o = ~stage_q[STAGES-1] & last_q;
endmodule

// File: rtl/csp_tx_shift.sv
module csp_tx_shift #(
  parameter int FRAME_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sdo_o,
  output logic               oe_o
);
  logic [FRAME_W-1:0] sreg_q;
  logic               oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      oe_q   <= 1'b0;
    end else if (start_i) begin
      sreg_q <= frame_i;
      oe_q   <= 1'b1;
    end else if (stop_i) begin
      sreg_q <= '0;
      oe_q   <= 1'b0;
    end else if (shift_i && oe_q) begin
      // zero fill: bits past the frame read as 0
      sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & sreg_q[FRAME_W-1];
endmodule

// File: rtl/csp_rx_shift.sv
module csp_rx_shift #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         commit_i,
  output logic [W-1:0] val_o,
  output logic         upd_o
);
  logic [W-1:0] sreg_q;
  logic [W-1:0] val_q;
  logic         upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clr_i)   sreg_q <= '0;
    else if (shift_i) sreg_q <= {sreg_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= RST_VAL;
      upd_q <= 1'b0;
    end else begin
      upd_q <= commit_i;
      if (commit_i) val_q <= sreg_q;
    end
  end

  assign val_o = val_q;
  assign upd_o = upd_q;
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import csp_pkg::*;
#(
  parameter int                MAG_W       = 16,
  parameter int                LOAD_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [LOAD_W-1:0] LOAD_RST    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              rd_ni,
  input  logic              ld_ni,
  input  logic              res_ovr_i,
  input  logic              res_pol_i,
  input  logic [MAG_W-1:0]  res_mag_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [LOAD_W-1:0] load_val_o,
  output logic              load_upd_o
);
  localparam int FRAME_W = MAG_W + 2;

  pins_t pins_raw, pins_s, pins_r, pins_f;

  assign pins_raw = '{sclk: sclk_i, sdi: sdi_i, rd_n: rd_ni, ld_n: ld_ni};

  // sdi travels with sclk so it is aligned at the detected edge
  csp_sync_edge #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_raw),
    .sync_o (pins_s),
    .rise_o (pins_r),
    .fall_o (pins_f)
  );

  logic [FRAME_W-1:0] frame;
  assign frame = {res_ovr_i, res_pol_i, res_mag_i};

  csp_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pins_f.rd_n),
    .stop_i (pins_r.rd_n),
    .shift_i(pins_f.sclk),
    .frame_i(frame),
    .sdo_o  (sdo_o),
    .oe_o   (sdo_oe_o)
  );

  csp_rx_shift #(.W(LOAD_W), .RST_VAL(LOAD_RST)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (pins_f.ld_n),
    .shift_i (pins_r.sclk & ~pins_s.ld_n),
    .bit_i   (pins_s.sdi),
    .commit_i(pins_r.ld_n),
    .val_o   (load_val_o),
    .upd_o   (load_upd_o)
  );
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int LOAD_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_ni,
  input logic              ld_ni,
  input logic              sdo_oe_o,
  input logic [LOAD_W-1:0] load_val_o,
  input logic              load_upd_o
);
  // R5: deselected for four samples means output released
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni && $past(rd_ni) && $past(rd_ni, 2) && $past(rd_ni, 3)) |-> !sdo_oe_o);

  // R2: enable only turns on after read select was low
  p_enable_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> !$past(rd_ni, 3));

  // R8: update is a single-cycle pulse
  p_upd_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_upd_o |=> !load_upd_o);

  // R8: update follows the strobe going high
  p_upd_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_upd_o |-> $past(ld_ni, 3));

  // R10: load value moves only with an update pulse
  p_val_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(load_val_o) |-> load_upd_o);
endmodule

bind conv_serial_port csp_checker #(.LOAD_W(LOAD_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_ni     (rd_ni),
  .ld_ni     (ld_ni),
  .sdo_oe_o  (sdo_oe_o),
  .load_val_o(load_val_o),
  .load_upd_o(load_upd_o)
);

// File: tb/conv_serial_port_tb_top.sv
module conv_serial_port_tb_top;
  localparam int HALF = 6;  // system clocks per data-clock half period

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk_i = 1'b0;
  logic        sdi_i = 1'b0;
  logic        rd_ni = 1'b1;
  logic        ld_ni = 1'b1;
  logic        res_ovr_i = 1'b0;
  logic        res_pol_i = 1'b0;
  logic [15:0] res_mag_i = '0;
  logic        sdo_o, sdo_oe_o, load_upd_o;
  logic [7:0]  load_val_o;

  int n_chk = 0;
  int n_fail = 0;
  int upd_cnt = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];

  always #4 clk_i = ~clk_i;

  conv_serial_port dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .rd_ni(rd_ni), .ld_ni(ld_ni), .res_ovr_i(res_ovr_i), .res_pol_i(res_pol_i),
    .res_mag_i(res_mag_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .load_val_o(load_val_o), .load_upd_o(load_upd_o)
  );

  always @(posedge clk_i) if (load_upd_o) upd_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected serial bits and compares with the output
  initial begin
    forever begin
      logic  e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(sdo_o === e && sdo_oe_o === 1'b1, t, {sdo_oe_o, sdo_o}, {1'b1, e});
    end
  end

  task automatic expect_bit(input logic b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
    wait (exp_q.size() == 0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse();
    sclk_i = 1'b1; wait_clk(HALF);
    sclk_i = 1'b0; wait_clk(HALF);
  endtask

  task automatic set_res(input logic o, input logic p, input logic [15:0] m);
    res_ovr_i = o; res_pol_i = p; res_mag_i = m;
  endtask

  // full read; optionally scramble the result inputs after the snapshot
  task automatic read_frame(input logic [17:0] f, input bit scramble, input int extra);
    rd_ni = 1'b0; wait_clk(HALF);
    if (scramble) set_res(~f[17], ~f[16], ~f[15:0]);
    check(sdo_oe_o === 1'b1, "R2 oe", sdo_oe_o, 1);
    expect_bit(f[17], "R2 first bit overrange");
    for (int i = 1; i < 18; i++) begin
      pulse();
      expect_bit(f[17-i], scramble ? "R4 snapshot bit" : "R3 frame bit");
    end
    for (int i = 0; i < extra; i++) begin
      pulse();
      expect_bit(1'b0, "R6 past end");
    end
    rd_ni = 1'b1; wait_clk(HALF);
    check(sdo_oe_o === 1'b0 && sdo_o === 1'b0, "R5 release", {sdo_oe_o, sdo_o}, 0);
  endtask

  task automatic load_bits(input logic [15:0] bits, input int n);
    ld_ni = 1'b0; wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi_i = bits[i]; wait_clk(HALF);
      sclk_i = 1'b1; wait_clk(HALF);
      sclk_i = 1'b0;
    end
    wait_clk(HALF);
    ld_ni = 1'b1; wait_clk(HALF);
  endtask

  initial begin
    #500us;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    // R1 reset state
    check(sdo_oe_o === 1'b0 && sdo_o === 1'b0, "R1 output idle", {sdo_oe_o, sdo_o}, 0);
    check(load_val_o === 8'h00, "R1 load value", load_val_o, 0);
    check(load_upd_o === 1'b0, "R1 update", load_upd_o, 0);

    // R3 plain frame, R6 tail
    set_res(1'b1, 1'b0, 16'hA5C3);
    read_frame({1'b1, 1'b0, 16'hA5C3}, 0, 3);

    // R4 inputs change during read
    set_res(1'b0, 1'b1, 16'h8001);
    read_frame({1'b0, 1'b1, 16'h8001}, 1, 0);

    // R5 abort mid-frame, R7 clocks while deselected
    set_res(1'b1, 1'b1, 16'h00F0);
    rd_ni = 1'b0; wait_clk(HALF);
    expect_bit(1'b1, "R5 pre-abort bit0");
    pulse(); expect_bit(1'b1, "R5 pre-abort bit1");
    pulse(); expect_bit(1'b0, "R5 pre-abort bit2");
    rd_ni = 1'b1; wait_clk(3);
    check(sdo_oe_o === 1'b0, "R5 abort release", sdo_oe_o, 0);
    wait_clk(HALF);
    for (int i = 0; i < 4; i++) pulse();
    check(sdo_oe_o === 1'b0 && sdo_o === 1'b0, "R7 idle clocks", {sdo_oe_o, sdo_o}, 0);
    set_res(1'b0, 1'b0, 16'hFFFF);
    read_frame({1'b0, 1'b0, 16'hFFFF}, 0, 0);

    // R8 full byte
    c0 = upd_cnt;
    load_bits(16'h00B6, 8);
    check(load_val_o === 8'hB6, "R8 load byte", load_val_o, 8'hB6);
    check(upd_cnt == c0 + 1, "R8 one pulse", upd_cnt - c0, 1);

    // R9 short and long sequences
    load_bits(16'h0005, 3);
    check(load_val_o === 8'h05, "R9 short load", load_val_o, 8'h05);
    load_bits(16'h0353, 10);
    check(load_val_o === 8'h53, "R9 long load", load_val_o, 8'h53);

    // R10 data clock with strobe high
    c0 = upd_cnt;
    sdi_i = 1'b1;
    set_res(1'b1, 1'b0, 16'h1234);
    read_frame({1'b1, 1'b0, 16'h1234}, 0, 0);
    check(load_val_o === 8'h53, "R10 value held", load_val_o, 8'h53);
    check(upd_cnt == c0, "R10 no pulse", upd_cnt - c0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule